// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags

This block buffers received serial characters between a deserializer and a host read path. Every stored character travels with three tags: break, framing error and parity error. The host can look at the oldest character's tags through a status read, which leaves the FIFO untouched. It then takes the character itself with a data read, which removes it.

Next to the head-entry view, the block keeps a count of tagged entries held anywhere in the FIFO. This count drives an aggregate error flag that stays high until the last tagged character has been drained. A data-ready flag shows that the FIFO is not empty. An overrun flag records that a character arrived with no room left and was dropped.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the FIFO is empty, and data_rdy, fifo_err, overrun, rd_data and the three head tags are all 0.
- R2: Each accepted write stores the character and its three tags. Characters leave in arrival order. head_brk, head_frm, head_par and rd_data always show the oldest stored entry.
- R3: A status read (stat_rd) never removes an entry and never changes the head outputs.
- R4: A data read (data_rd) on a non-empty FIFO removes the head entry one clock later. A data read on an empty FIFO has no effect.
- R5: fifo_err is 1 exactly while at least one stored entry has any tag set. A tagged entry sitting behind clean entries keeps the flag set. The flag clears only once the last tagged entry has been popped.
- R6: data_rdy is 1 exactly while the FIFO holds at least one character.
- R7: A write with wr_brk = 1 stores the character value 0, whatever is on wr_data.
- R8: A write that arrives when the FIFO is full and no pop happens in the same cycle is discarded, and overrun becomes 1. overrun clears after a status read. If a new overrun and a status read fall in the same cycle, overrun stays 1.
- R9: While the FIFO is empty, rd_data and the three head tags read 0.
- R10: The FIFO holds DEPTH (default 64) characters. A write in the same cycle as a pop on a full FIFO is accepted, and the FIFO stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one received character |
| wr_data | input | DATA_W | Received character |
| wr_brk | input | 1 | Break tag of the written character |
| wr_frm | input | 1 | Framing-error tag of the written character |
| wr_par | input | 1 | Parity-error tag of the written character |
| stat_rd | input | 1 | Status read strobe; does not pop |
| data_rd | input | 1 | Data read strobe; pops the head entry |
| rd_data | output | DATA_W | Character at the head |
| head_brk | output | 1 | Break tag of the head entry |
| head_frm | output | 1 | Framing tag of the head entry |
| head_par | output | 1 | Parity tag of the head entry |
| fifo_err | output | 1 | Some entry in the FIFO carries a tag |
| data_rdy | output | 1 | FIFO holds at least one character |
| overrun | output | 1 | A character was dropped because the FIFO was full |

## Verification
The bench places a tagged entry behind clean ones and drains them one at a time. A design that derives the aggregate flag from the head entry alone would drop fifo_err too early here, or raise it too late. The bench fills all 64 slots and then writes again, both with and without a pop in the same cycle. An off-by-one in the full test would either lose a character or accept one too many. It also lines up an overrun with a status read, where clear-wins logic would lose the overrun. Status reads are mixed into long random traffic, so a status read that popped an entry would put the head outputs out of step with the reference queue.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxf_tag_t;

    function automatic logic tag_any(input rxf_tag_t t);
        return t.brk | t.frm | t.par;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    input  rxf_tag_t          wtag,
    output logic [DATA_W-1:0] hdata,
    output rxf_tag_t          htag,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [DATA_W-1:0] dmem [DEPTH];
    rxf_tag_t          tmem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = bump(s_q.wr);
        if (pop)  s_d.rd = bump(s_q.rd);
        case ({push, pop})
            2'b10:   s_d.lvl = s_q.lvl + 1'b1;
            2'b01:   s_d.lvl = s_q.lvl - 1'b1;
            default: s_d.lvl = s_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            dmem[s_q.wr] <= wdata;
            tmem[s_q.wr] <= wtag;
        end
    end

    assign empty = (s_q.lvl == '0);
    assign full  = (s_q.lvl == LW'(DEPTH));
    assign level = s_q.lvl;
    assign hdata = empty ? '0 : dmem[s_q.rd];
    assign htag  = empty ? '0 : tmem[s_q.rd];

    // R10: occupancy never exceeds capacity
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lvl <= LW'(DEPTH));
    // R4: no pop request reaches an empty store
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R3: without push or pop the occupancy holds
    a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(s_q.lvl));
endmodule

// File: rtl/rxf_errcnt.sv
module rxf_errcnt #(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc,
    input  logic                       dec,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       any
);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [LW-1:0] n;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        case ({inc, dec})
            2'b10:   c_d.n = c_q.n + 1'b1;
            2'b01:   c_d.n = c_q.n - 1'b1;
            default: c_d.n = c_q.n;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.n;
    assign any = (c_q.n != '0);

    // R5: a tagged pop only happens while tagged entries are counted
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (c_q.n != '0));
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_brk,
    input  logic              wr_frm,
    input  logic              wr_par,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              head_brk,
    output logic              head_frm,
    output logic              head_par,
    output logic              fifo_err,
    output logic              data_rdy,
    output logic              overrun
);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic ovr;
    } flag_t;

    flag_t f_d, f_q;
    logic push, pop, full, empty;
    logic [LW-1:0] level, err_cnt;
    rxf_tag_t wtag, htag;
    logic [DATA_W-1:0] wdata;

    assign wtag  = '{brk: wr_brk, frm: wr_frm, par: wr_par};
    assign wdata = wr_brk ? '0 : wr_data;
    assign pop   = data_rd && !empty;
    assign push  = wr_en && (!full || pop);

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wdata(wdata), .wtag(wtag), .hdata(rd_data), .htag(htag),
        .level(level), .full(full), .empty(empty)
    );

    rxf_errcnt #(.DEPTH(DEPTH)) u_errcnt (
        .clk(clk), .rst_n(rst_n),
        .inc(push && tag_any(wtag)), .dec(pop && tag_any(htag)),
        .cnt(err_cnt), .any(fifo_err)
    );

    always_comb begin
        f_d = f_q;
        if (stat_rd) f_d.ovr = 1'b0;
        if (wr_en && !push) f_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign overrun  = f_q.ovr;
    assign data_rdy = !empty;
    assign head_brk = htag.brk;
    assign head_frm = htag.frm;
    assign head_par = htag.par;

    // R5: tagged-entry count can never exceed the number of entries
    a_r5_err_within_level: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= level);
    // R8: a dropped write leaves overrun raised
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !data_rd) |=> overrun);
    // R9: an empty FIFO shows clean head tags
    a_r9_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rdy |-> !(head_brk || head_frm || head_par));
    // R6: popping the only entry with no write empties the FIFO
    a_r6_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && level == LW'(1) && !wr_en) |=> !data_rdy);
endmodule

// File: tb/rx_err_fifo_tb.sv
module rx_err_fifo_tb;
    localparam int DW = 8;
    localparam int DEPTH = 64;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, wr_brk = 0, wr_frm = 0, wr_par = 0, stat_rd = 0, data_rd = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic head_brk, head_frm, head_par, fifo_err, data_rdy, overrun;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [10:0] q[$];   // {brk,frm,par,data}
    bit m_ovr = 0;

    always #2 clk = ~clk;

    rx_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par),
        .stat_rd(stat_rd), .data_rd(data_rd), .rd_data(rd_data),
        .head_brk(head_brk), .head_frm(head_frm), .head_par(head_par),
        .fifo_err(fifo_err), .data_rdy(data_rdy), .overrun(overrun)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [10:0] h;
        bit anyerr;
        h = (q.size() > 0) ? q[0] : 11'h0;
        anyerr = 0;
        foreach (q[i]) if (q[i][10:8] != 0) anyerr = 1;
        chk(rd_data, h[7:0], "R2/R9 rd_data");
        chk({head_brk, head_frm, head_par}, h[10:8], "R2/R9 head tags");
        chk(data_rdy, q.size() > 0, "R6 data_rdy");
        chk(fifo_err, anyerr, "R5 fifo_err");
        chk(overrun, m_ovr, "R8 overrun");
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit w, input logic [7:0] d, input logic [2:0] t,
                        input bit sr, input bit dr);
        bit pop, full, acc;
        wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = t;
        stat_rd = sr; data_rd = dr;
        @(posedge clk);
        pop  = dr && q.size() > 0;
        full = q.size() == DEPTH;
        acc  = w && (!full || pop);
        if (pop) void'(q.pop_front());
        if (acc) q.push_back({t, t[2] ? 8'h00 : d});
        if (sr) m_ovr = 0;
        if (w && !acc) m_ovr = 1;
        @(negedge clk);
        wr_en = 0; stat_rd = 0; data_rd = 0;
        compare_all();
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk({data_rdy, fifo_err, overrun, head_brk, head_frm, head_par}, 0, "R1 reset flags");
        chk(rd_data, 0, "R1 reset rd_data");
        rst_n = 1;
        @(negedge clk);
        compare_all();

        // R4: pop on empty ignored; R9 empty head clean
        step(0, 0, 0, 0, 1);
        chk(data_rdy, 0, "R4 pop empty");

        // R2/R7: varied entries
        step(1, 8'h41, 3'b000, 0, 0);
        step(1, 8'hA5, 3'b100, 0, 0);
        step(1, 8'h33, 3'b010, 0, 0);
        step(1, 8'h7E, 3'b001, 0, 0);
        chk(rd_data, 8'h41, "R2 oldest at head");
        // R3: status reads do not pop
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        chk(rd_data, 8'h41, "R3 status no pop");
        chk(fifo_err, 1, "R5 tagged behind clean");
        step(0, 0, 0, 0, 1);
        chk(head_brk, 1, "R2 break tag at head");
        chk(rd_data, 8'h00, "R7 break stores zero");
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        chk(fifo_err, 1, "R5 last tagged remains");
        step(0, 0, 0, 0, 1);
        chk(fifo_err, 0, "R5 cleared after drain");
        chk(data_rdy, 0, "R6 empty after drain");

        // R10: fill to DEPTH, then overrun
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i), (i == 63) ? 3'b010 : 3'b000, 0, 0);
        chk(data_rdy, 1, "R10 full");
        step(1, 8'hEE, 3'b001, 0, 0);
        chk(overrun, 1, "R8 overrun set");
        step(1, 8'hDD, 3'b000, 0, 1);   // push+pop on full accepted
        chk(rd_data, 1, "R10 pop on full");
        step(1, 8'hCC, 3'b000, 1, 0);   // overrun again and status read: set wins
        chk(overrun, 1, "R8 set wins over clear");
        step(0, 0, 0, 1, 0);
        chk(overrun, 0, "R8 cleared by status read");
        for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 0, 1);
        chk(rd_data, 8'hDD, "R10 accepted write at tail");
        step(0, 0, 0, 0, 1);

        // mixed random traffic
        for (int i = 0; i < 3000; i++)
            step($urandom_range(0, 99) < 55, 8'($urandom), 3'($urandom_range(0, 7) & (($urandom_range(0,3)==0) ? 7 : 0)),
                 $urandom_range(0, 9) == 0, $urandom_range(0, 99) < 50);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule